// File: doc/BRIEF.md
# Serial-bus register target with time snapshot

This block is a target on a two-wire serial bus (I2C) that exposes a 64-byte register space. Addresses 0 to 6 carry the time fields of an external timekeeper, address 7 is a control and status byte, and addresses 8 to 63 are general-purpose storage. The bus lines are sampled in the system clock domain. The data line is driven open-drain through `sda_oe`, which pulls the line low while it is 1. The block never stretches the clock line.

A write transfer loads an internal register pointer from its first data byte. Each later byte is stored at the pointer, and the pointer then advances, wrapping from 63 to 0. A read transfer returns bytes from the pointer onward. Time fields are read from a snapshot, which is copied from `live_time` on every START and every time the pointer advances to 0. As a result, a multibyte read of the time sees one consistent instant. Writes to time fields appear as a one-cycle strobe toward the timekeeper. Two status bits of the control byte can be set by hardware and can only be cleared by the bus. If the clock line is held low past a timeout, the interface resets.

The state machine has eight states:
- IDLE: waits for START.
- ADDR: shifts in the address byte.
- ADDR_ACK: the target acknowledges its address.
- WR_BYTE: shifts in a write byte.
- WR_ACK: the target acknowledges that byte.
- RD_BYTE: shifts out a read byte.
- RD_ACK: samples the master's acknowledge.
- IGNORE: stays silent until the next START.

Transitions:
- START moves any state to ADDR.
- STOP or timeout moves any state to IDLE.
- ADDR goes to ADDR_ACK on a match, or to IGNORE on a mismatch.
- ADDR_ACK goes to RD_BYTE or WR_BYTE, depending on the direction bit.
- WR_BYTE and WR_ACK alternate.
- RD_BYTE goes to RD_ACK.
- RD_ACK goes to RD_BYTE when the master acknowledges, or to IGNORE when it does not.

Top module: `rtc_i2c_target`

## Requirements
- R1: The target acknowledges only the address bytes 0xD0 (write) and 0xD1 (read), where the upper seven bits are 1101000. Any other address byte gets no acknowledge, and all bytes that follow it are neither acknowledged nor stored until the next START.
- R2: In a write, the first data byte sets the pointer to its low six bits. Each later byte is stored at the pointer, after which the pointer increments.
- R3: The pointer wraps from 0x3F to 0x00 during multibyte reads and writes.
- R4: `live_time` byte i (bits 8i+7:8i) is copied into the snapshot on every START, including a repeated START, and whenever the pointer advances to 0x00. Reads of addresses 0 to 6 return the snapshot.
- R5: A byte written to an address from 0 to 6 is committed when the target drives its acknowledge. It appears as a one-cycle `time_wr_en` pulse carrying the address and data, and no pulse occurs for any other write.
- R6: A read starts at the current pointer. A master acknowledge (SDA low in the ninth clock) requests the next byte. A master not-acknowledge releases SDA and ends the read.
- R7: If SCL stays low for TIMEOUT_CYC system clocks while a transfer is active, SDA is released and the target waits for a new START.
- R8: Control byte 7 resets to 0xBF. Bits 5 and 3 are set by `osc_stop_set` and `sig_loss_set` respectively. A bus write of 0 clears them, and a bus write of 1 leaves them unchanged. The other bits take the written value.
- R9: The target changes SDA only while SCL is low, and shifts data out MSB first.
- R10: A repeated START returns the target to address reception without changing the pointer.
- R11: After reset, SDA is released and the control byte reads 0xBF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin |
| sda_oe | output | 1 | Pulls the data line low when 1 |
| live_time | input | 8*TIME_REGS | Current time fields from the timekeeper, byte i is address i |
| osc_stop_set | input | 1 | Sets control bit 5 |
| sig_loss_set | input | 1 | Sets control bit 3 |
| time_wr_en | output | 1 | One-cycle strobe for a bus write to a time field |
| time_wr_addr | output | clog2(TIME_REGS) | Time field address of that write |
| time_wr_data | output | 8 | Data of that write |
| ctrl_q | output | 8 | Current control byte |

## Verification
Multibyte writes into storage, followed by reads through a repeated START and through a plain read, show that the pointer loads, advances and survives a restart. A write and a read running across the 0x3F boundary use values of `live_time` that change between the START, the repeated START and the wrap. This tells apart a snapshot taken at START, one taken at wrap, and no snapshot at all. A foreign address followed by a pointer byte and data shows whether ignored traffic leaks into storage or into the time strobe. Clear-only status bits are written with 0 and with 1, after a hardware set. Finally, SCL is held low while the target drives a 0 bit, which shows the timeout release.

// File: rtl/rtc_i2c_pkg.sv
package rtc_i2c_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK,
        ST_IGNORE
    } bus_state_e;

    localparam logic [6:0] DEV_ADDR  = 7'b1101000;
    localparam logic [7:0] CLR_MASK  = 8'h28;
    localparam logic [7:0] CTRL_RST  = 8'hBF;
    localparam int         OSC_BIT   = 5;
    localparam int         LOSS_BIT  = 3;

endpackage

// File: rtl/rtc_i2c_sync.sv
module rtc_i2c_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_p,
    output logic stop_p
);
    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_d;
    logic              sda_d;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= scl_i;
                    sda_ff <= sda_i;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= {scl_ff[STAGES-2:0], scl_i};
                    sda_ff <= {sda_ff[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_s = scl_ff[STAGES-1];
    assign sda_s = sda_ff[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_d;
    assign scl_fall = ~scl_s & scl_d;
    assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/rtc_i2c_regbank.sv
module rtc_i2c_regbank
    import rtc_i2c_pkg::*;
#(
    parameter int AW        = 6,
    parameter int TIME_REGS = 7,
    localparam int SW       = $clog2(TIME_REGS),
    localparam int DEPTH    = 2 ** AW,
    localparam int CTRL_A   = TIME_REGS,
    localparam int RAM_LO   = TIME_REGS + 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   snap_en,
    input  logic [8*TIME_REGS-1:0] live_time,
    input  logic                   we,
    input  logic [AW-1:0]          waddr,
    input  logic [7:0]             wdata,
    input  logic [AW-1:0]          raddr,
    output logic [7:0]             rdata,
    input  logic                   osc_stop_set,
    input  logic                   sig_loss_set,
    output logic                   time_wr_en,
    output logic [SW-1:0]          time_wr_addr,
    output logic [7:0]             time_wr_data,
    output logic [7:0]             ctrl_q
);
    logic [7:0]             ram [RAM_LO:DEPTH-1];
    logic [7:0]             snap [TIME_REGS];
    logic [8*TIME_REGS-1:0] snap_flat;
    logic [7:0]             ctrl_nx;
    logic [7:0]             set_bits;

    genvar gi;
    generate
        for (gi = 0; gi < TIME_REGS; gi++) begin : g_snap
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    snap[gi] <= '0;
                else if (snap_en)
                    snap[gi] <= live_time[8*gi +: 8];
            end
            assign snap_flat[8*gi +: 8] = snap[gi];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (we && (int'(waddr) >= RAM_LO))
            ram[waddr] <= wdata;
    end

    always_comb begin
        set_bits           = '0;
        set_bits[OSC_BIT]  = osc_stop_set;
        set_bits[LOSS_BIT] = sig_loss_set;
        ctrl_nx            = ctrl_q;
        if (we && (int'(waddr) == CTRL_A))
            ctrl_nx = (wdata & ~CLR_MASK) | (ctrl_q & wdata & CLR_MASK);
        ctrl_nx = ctrl_nx | set_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctrl_q <= CTRL_RST;
        else
            ctrl_q <= ctrl_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            time_wr_en   <= 1'b0;
            time_wr_addr <= '0;
            time_wr_data <= '0;
        end else begin
            time_wr_en <= we && (int'(waddr) < TIME_REGS);
            if (we) begin
                time_wr_addr <= waddr[SW-1:0];
                time_wr_data <= wdata;
            end
        end
    end

    always_comb begin
        if (int'(raddr) < TIME_REGS)
            rdata = snap[raddr[SW-1:0]];
        else if (int'(raddr) == CTRL_A)
            rdata = ctrl_q;
        else
            rdata = ram[raddr];
    end

    // R8
    clr_only_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[OSC_BIT] && !(we && int'(waddr) == CTRL_A && !wdata[OSC_BIT]))
        |=> ctrl_q[OSC_BIT]);

    // R8
    clr_only_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && int'(waddr) == CTRL_A && !wdata[OSC_BIT] && !osc_stop_set)
        |=> !ctrl_q[OSC_BIT]);

    // R4
    snap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snap_en |=> (snap_flat == $past(live_time)));

    // R5
    commit_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && int'(waddr) < TIME_REGS) |=> (time_wr_en && time_wr_data == $past(wdata)));

endmodule

// File: rtl/rtc_i2c_target.sv
module rtc_i2c_target
    import rtc_i2c_pkg::*;
#(
    parameter int AW          = 6,
    parameter int TIME_REGS   = 7,
    parameter int TIMEOUT_CYC = 2000,
    parameter int SYNC_STAGES = 2,
    localparam int SW         = $clog2(TIME_REGS),
    localparam int TO_W       = $clog2(TIMEOUT_CYC)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   scl_i,
    input  logic                   sda_i,
    output logic                   sda_oe,
    input  logic [8*TIME_REGS-1:0] live_time,
    input  logic                   osc_stop_set,
    input  logic                   sig_loss_set,
    output logic                   time_wr_en,
    output logic [SW-1:0]          time_wr_addr,
    output logic [7:0]             time_wr_data,
    output logic [7:0]             ctrl_q
);
    bus_state_e      state, state_nx;
    logic            scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
    logic [3:0]      bitcnt;
    logic [7:0]      shreg;
    logic [AW-1:0]   ptr;
    logic [AW-1:0]   ptr_nx;
    logic            rw, first_wr, mack;
    logic            wr_en;
    logic [AW-1:0]   wr_addr;
    logic [7:0]      wr_data;
    logic            snap_en;
    logic [7:0]      rdata;
    logic [TO_W-1:0] to_cnt;
    logic            to_hit;
    logic            addr_hit;

    rtc_i2c_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_p(start_p), .stop_p(stop_p)
    );

    rtc_i2c_regbank #(.AW(AW), .TIME_REGS(TIME_REGS)) u_bank (
        .clk(clk), .rst_n(rst_n), .snap_en(snap_en), .live_time(live_time),
        .we(wr_en), .waddr(wr_addr), .wdata(wr_data), .raddr(ptr), .rdata(rdata),
        .osc_stop_set(osc_stop_set), .sig_loss_set(sig_loss_set),
        .time_wr_en(time_wr_en), .time_wr_addr(time_wr_addr),
        .time_wr_data(time_wr_data), .ctrl_q(ctrl_q)
    );

    assign addr_hit = (shreg[7:1] == DEV_ADDR);
    assign ptr_nx   = ptr + AW'(1);
    assign to_hit   = (to_cnt == TO_W'(TIMEOUT_CYC - 1)) && !scl_s && (state != ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            to_cnt <= '0;
        else if (scl_s || state == ST_IDLE)
            to_cnt <= '0;
        else if (to_cnt != TO_W'(TIMEOUT_CYC - 1))
            to_cnt <= to_cnt + TO_W'(1);
    end

    always_comb begin
        state_nx = state;
        if (start_p)
            state_nx = ST_ADDR;
        else if (stop_p || to_hit)
            state_nx = ST_IDLE;
        else begin
            unique case (state)
                ST_IDLE:     state_nx = ST_IDLE;
                ST_IGNORE:   state_nx = ST_IGNORE;
                ST_ADDR:     if (scl_fall && bitcnt == 4'd8)
                                 state_nx = addr_hit ? ST_ADDR_ACK : ST_IGNORE;
                ST_ADDR_ACK: if (scl_fall)
                                 state_nx = rw ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:  if (scl_fall && bitcnt == 4'd8)
                                 state_nx = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall)
                                 state_nx = ST_WR_BYTE;
                ST_RD_BYTE:  if (scl_fall && bitcnt == 4'd7)
                                 state_nx = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall)
                                 state_nx = mack ? ST_RD_BYTE : ST_IGNORE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_oe   <= 1'b0;
            bitcnt   <= '0;
            shreg    <= '0;
            ptr      <= '0;
            rw       <= 1'b0;
            first_wr <= 1'b0;
            mack     <= 1'b0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            snap_en  <= 1'b0;
        end else begin
            wr_en   <= 1'b0;
            snap_en <= 1'b0;
            if (start_p) begin
                bitcnt  <= '0;
                sda_oe  <= 1'b0;
                snap_en <= 1'b1;
            end else if (stop_p || to_hit) begin
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_WR_BYTE: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[6:0], sda_s};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (scl_fall && bitcnt == 4'd8) begin
                            bitcnt <= '0;
                            if (state == ST_ADDR) begin
                                rw       <= shreg[0];
                                sda_oe   <= addr_hit;
                                first_wr <= 1'b1;
                            end else begin
                                sda_oe <= 1'b1;
                                if (first_wr) begin
                                    ptr      <= shreg[AW-1:0];
                                    first_wr <= 1'b0;
                                end else begin
                                    wr_en   <= 1'b1;
                                    wr_addr <= ptr;
                                    wr_data <= shreg;
                                    ptr     <= ptr_nx;
                                    snap_en <= (ptr_nx == '0);
                                end
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (rw) begin
                                shreg  <= rdata;
                                sda_oe <= ~rdata[7];
                            end else begin
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_WR_ACK: begin
                        if (scl_fall)
                            sda_oe <= 1'b0;
                    end
                    ST_RD_BYTE: begin
                        if (scl_fall) begin
                            if (bitcnt == 4'd7) begin
                                sda_oe  <= 1'b0;
                                ptr     <= ptr_nx;
                                snap_en <= (ptr_nx == '0);
                            end else begin
                                shreg  <= {shreg[6:0], 1'b0};
                                sda_oe <= ~shreg[6];
                                bitcnt <= bitcnt + 4'd1;
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise)
                            mack <= ~sda_s;
                        else if (scl_fall && mack) begin
                            bitcnt <= '0;
                            shreg  <= rdata;
                            sda_oe <= ~rdata[7];
                        end
                    end
                    ST_IDLE, ST_IGNORE: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

    // R7
    timeout_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        to_hit |=> (state == ST_IDLE && !sda_oe));

    // R9
    sda_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_oe));

    // R1
    ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGNORE || state == ST_IDLE) |-> !sda_oe);

    // R10
    restart_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_p |=> $stable(ptr));

    // R3
    wrap_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD_BYTE && scl_fall && bitcnt == 4'd7 && !start_p && !stop_p
         && ptr == '1) |=> (ptr == '0 && snap_en));

endmodule

// File: tb/rtc_i2c_target_tb.sv
module rtc_i2c_target_tb;

    localparam int Q  = 10;
    localparam int TO = 2000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_line;
    logic        sda_oe;
    logic [55:0] live;
    logic        osc_set = 1'b0;
    logic        los_set = 1'b0;
    logic        time_wr_en;
    logic [2:0]  time_wr_addr;
    logic [7:0]  time_wr_data;
    logic [7:0]  ctrl_q;

    int          n_vec = 0;
    int          n_bad = 0;
    bit          done  = 0;
    logic [7:0]  exp_q[$];
    string       exp_tag[$];
    logic [7:0]  act_q[$];
    logic [10:0] tw_exp_q[$];

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    rtc_i2c_target #(.TIMEOUT_CYC(TO)) u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
        .live_time(live), .osc_stop_set(osc_set), .sig_loss_set(los_set),
        .time_wr_en(time_wr_en), .time_wr_addr(time_wr_addr),
        .time_wr_data(time_wr_data), .ctrl_q(ctrl_q)
    );

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wq(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(Q);
        scl_m = 1'b1; wq(Q);
        sda_m = 1'b1; wq(Q);
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(Q);
            scl_m = 1'b1; wq(2*Q);
            scl_m = 1'b0; wq(Q);
        end
        sda_m = 1'b1; wq(Q);
        scl_m = 1'b1; wq(Q);
        ack = ~sda_line; wq(Q);
        scl_m = 1'b0; wq(Q);
    endtask

    task automatic rbyte(input logic give_ack);
        logic [7:0] b;
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(Q);
            scl_m = 1'b1; wq(Q);
            b[i] = sda_line; wq(Q);
            scl_m = 1'b0; wq(Q);
        end
        act_q.push_back(b);
        sda_m = ~give_ack; wq(Q);
        scl_m = 1'b1; wq(2*Q);
        scl_m = 1'b0; wq(Q);
        sda_m = 1'b1;
    endtask

    task automatic expect_rd(string tag, logic [7:0] v);
        exp_q.push_back(v);
        exp_tag.push_back(tag);
    endtask

    task automatic wr_ack(string tag, logic [7:0] b);
        logic a;
        wbyte(b, a);
        chk(tag, {15'd0, a}, 16'd1);
    endtask

    // monitor: compares read bytes and time-field write strobes against queues
    always @(negedge clk) begin
        if (act_q.size() > 0) begin
            logic [7:0] a;
            a = act_q.pop_front();
            if (exp_q.size() == 0)
                chk("R6 unexpected read byte", {8'd0, a}, 16'hFFFF);
            else
                chk(exp_tag.pop_front(), {8'd0, a}, {8'd0, exp_q.pop_front()});
        end
        if (time_wr_en) begin
            if (tw_exp_q.size() == 0)
                chk("R5 unexpected time write", {5'd0, time_wr_addr, time_wr_data}, 16'hFFFF);
            else
                chk("R5 time write", {5'd0, time_wr_addr, time_wr_data}, {5'd0, tw_exp_q.pop_front()});
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic a;
        rst_n = 1'b0;
        live  = 56'h16_15_14_13_12_11_10;
        wq(5);
        rst_n = 1'b1;
        wq(3);
        // R11
        chk("R11 sda released after reset", {15'd0, sda_line}, 16'd1);
        chk("R11 control reset value", {8'd0, ctrl_q}, 16'h00BF);

        // R1, R2: write three storage bytes from pointer 0x08
        bus_start();
        wr_ack("R1 ack D0", 8'hD0);
        wr_ack("R2 ack pointer", 8'h08);
        wr_ack("R2 ack data", 8'hA1);
        wr_ack("R2 ack data", 8'hA2);
        wr_ack("R2 ack data", 8'hA3);
        bus_stop();

        // R10: repeated START keeps the pointer, R6 NACK ends the read
        bus_start();
        wr_ack("R1 ack D0", 8'hD0);
        wr_ack("R2 ack pointer", 8'h09);
        bus_start();
        wr_ack("R1 ack D1", 8'hD1);
        expect_rd("R10 read after restart", 8'hA2);
        expect_rd("R10 read after restart", 8'hA3);
        rbyte(1'b1);
        rbyte(1'b0);
        chk("R6 sda released after NACK", {15'd0, sda_line}, 16'd1);
        bus_stop();

        // R6: plain read starts at current pointer
        bus_start();
        wr_ack("R1 ack D0", 8'hD0);
        wr_ack("R2 ack pointer", 8'h08);
        bus_stop();
        bus_start();
        wr_ack("R1 ack D1", 8'hD1);
        expect_rd("R6 read from pointer", 8'hA1);
        expect_rd("R6 read continues on ACK", 8'hA2);
        rbyte(1'b1);
        rbyte(1'b0);
        bus_stop();

        // R3, R5: write across 0x3F into time fields 0 and 1
        tw_exp_q.push_back({3'd0, 8'h77});
        tw_exp_q.push_back({3'd1, 8'h88});
        bus_start();
        wr_ack("R1 ack D0", 8'hD0);
        wr_ack("R3 ack pointer", 8'h3E);
        wr_ack("R3 ack data", 8'h55);
        wr_ack("R3 ack data", 8'h66);
        wr_ack("R5 ack time data", 8'h77);
        wr_ack("R5 ack time data", 8'h88);
        bus_stop();
        wq(5);
        chk("R5 both time writes seen", tw_exp_q.size(), 16'd0);

        // R3, R4: read across wrap, snapshot at wrap uses latest live value
        live = 56'h26_25_24_23_22_21_20;
        bus_start();
        wr_ack("R1 ack D0", 8'hD0);
        wr_ack("R3 ack pointer", 8'h3E);
        live = 56'h36_35_34_33_32_31_30;
        bus_start();
        wr_ack("R1 ack D1", 8'hD1);
        live = 56'h46_45_44_43_42_41_40;
        expect_rd("R3 read 0x3E", 8'h55);
        expect_rd("R3 read 0x3F", 8'h66);
        expect_rd("R4 wrap snapshot byte0", 8'h40);
        expect_rd("R4 wrap snapshot byte1", 8'h41);
        rbyte(1'b1);
        rbyte(1'b1);
        rbyte(1'b1);
        rbyte(1'b0);
        bus_stop();

        // R4: snapshot at repeated START, live change afterwards not seen
        live = 56'h56_55_54_53_52_51_50;
        bus_start();
        wr_ack("R1 ack D0", 8'hD0);
        wr_ack("R4 ack pointer", 8'h05);
        live = 56'h66_65_64_63_62_61_60;
        bus_start();
        wr_ack("R1 ack D1", 8'hD1);
        live = 56'h76_75_74_73_72_71_70;
        expect_rd("R4 start snapshot byte5", 8'h65);
        expect_rd("R4 start snapshot byte6", 8'h66);
        rbyte(1'b1);
        rbyte(1'b0);
        bus_stop();

        // R1: foreign address, following bytes ignored
        bus_start();
        wbyte(8'hA0, a);
        chk("R1 no ack foreign address", {15'd0, a}, 16'd0);
        wbyte(8'h02, a);
        chk("R1 no ack while ignoring", {15'd0, a}, 16'd0);
        wbyte(8'h99, a);
        chk("R1 no ack while ignoring", {15'd0, a}, 16'd0);
        bus_stop();
        bus_start();
        wr_ack("R1 ack D0", 8'hD0);
        wr_ack("R1 ack pointer", 8'h08);
        bus_start();
        wr_ack("R1 ack D1", 8'hD1);
        expect_rd("R1 storage untouched", 8'hA1);
        rbyte(1'b0);
        bus_stop();

        // R8: clear-only status bits
        bus_start();
        wr_ack("R1 ack D0", 8'hD0);
        wr_ack("R8 ack pointer", 8'h07);
        wr_ack("R8 ack data", 8'h00);
        bus_stop();
        chk("R8 write zero clears", {8'd0, ctrl_q}, 16'h0000);
        osc_set = 1'b1; wq(1); osc_set = 1'b0; wq(2);
        chk("R8 hardware set bit5", {8'd0, ctrl_q}, 16'h0020);
        bus_start();
        wr_ack("R1 ack D0", 8'hD0);
        wr_ack("R8 ack pointer", 8'h07);
        wr_ack("R8 ack data", 8'h28);
        bus_stop();
        chk("R8 write one leaves flags", {8'd0, ctrl_q}, 16'h0020);
        bus_start();
        wr_ack("R1 ack D0", 8'hD0);
        wr_ack("R8 ack pointer", 8'h07);
        bus_start();
        wr_ack("R1 ack D1", 8'hD1);
        expect_rd("R8 control read back", 8'h20);
        rbyte(1'b0);
        bus_stop();

        // R5: single time-field write
        tw_exp_q.push_back({3'd2, 8'h45});
        bus_start();
        wr_ack("R1 ack D0", 8'hD0);
        wr_ack("R5 ack pointer", 8'h02);
        wr_ack("R5 ack time data", 8'h45);
        bus_stop();

        // R7, R9: timeout while target drives a 0 bit
        live = 56'h06_05_04_03_02_01_12;
        bus_start();
        wr_ack("R1 ack D0", 8'hD0);
        wr_ack("R7 ack pointer", 8'h00);
        bus_start();
        wr_ack("R1 ack D1", 8'hD1);
        chk("R9 MSB zero driven", {15'd0, sda_line}, 16'd0);
        wq(TO + 50);
        chk("R7 sda released on timeout", {15'd0, sda_line}, 16'd1);
        scl_m = 1'b1; wq(Q);
        bus_start();
        wr_ack("R7 ack after timeout", 8'hD0);
        bus_stop();

        wq(20);
        chk("R5 pending time writes", tw_exp_q.size(), 16'd0);
        chk("R6 pending read bytes", exp_q.size(), 16'd0);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule